// File: doc/BRIEF.md
# Saturating Rounding Narrowing Interleaver

This datapath takes two vectors of 32-bit unsigned lanes and turns them into one vector of 16-bit unsigned lanes with the same total width. Every source lane is shifted right by an amount chosen by a 4-bit code, with round-half-up applied first. Any result that does not fit in 16 bits is clamped to the largest 16-bit value. The narrowed results from the two sources are woven together lane by lane. Lanes from the first source land on even destination positions, and lanes from the second source land on odd positions.

An execution pipeline presents both operands and the code together with `in_valid`. It reads the packed result, plus a flag saying whether any lane was clamped, when `out_valid` is high. All lanes are written on every operation; there is no per-lane masking. A parameter selects between a purely combinational path and a single output register. The number of lanes per source is also a parameter.

Top module: `round_narrow_interleave`

## Requirements
- R1: The shift amount is 16 minus the unsigned value of `shift_code`, so codes 1..15 give shifts 15..1 and code 0 gives a shift of 16.
- R2: Before the logical right shift, each lane gets 2^(shift-1) added to it. The sum is formed without wrap-around, so 0xFFFFFFFF with code 0 yields 65536 before clamping, not 0.
- R3: A shifted value above 65535 produces 65535 in its destination lane. Values up to 65535 pass through unchanged.
- R4: Source lane e occupies bits [32e+31:32e] of `src_a` and `src_b`. Destination lane k occupies bits [16k+15:16k] of `dst`. Lane 2e comes from `src_a` lane e and lane 2e+1 comes from `src_b` lane e.
- R5: `sat_flag` is high for an operation exactly when at least one of its 2*LANES results was clamped.
- R6: With REG_OUT=1, `out_valid` equals `in_valid` of the previous clock, and `dst`/`sat_flag` show that operation's result. With REG_OUT=0, they follow the inputs in the same cycle.
- R7: With REG_OUT=1, a cycle with `in_valid` low leaves `dst` and `sat_flag` unchanged from the last operation.
- R8: While `rst_n` is low, and after its release until the first operation, `out_valid`, `dst` and `sat_flag` are all zero (REG_OUT=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and code are valid this cycle |
| src_a | input | 32*LANES | First source vector, even destination lanes |
| src_b | input | 32*LANES | Second source vector, odd destination lanes |
| shift_code | input | 4 | Encoded shift; shift = 16 - code |
| out_valid | output | 1 | Result valid |
| dst | output | 32*LANES | Interleaved 16-bit results |
| sat_flag | output | 1 | At least one lane clamped |

## Verification
The properties assume `in_valid` is held low while reset is asserted. They also assume the operand buses are stable whenever `in_valid` is high at a sampling edge. The bench meets both by driving every input only on the falling edge and keeping `in_valid` low through reset. The zero-operand property further assumes that `shift_code` can take any value. Stimulus therefore sweeps all sixteen codes, including the all-zero and all-ones operand patterns.

// File: rtl/rni_pkg.sv
package rni_pkg;
   localparam int unsigned SRC_W   = 32;
   localparam int unsigned DST_W   = 16;
   localparam int unsigned CODE_W  = 4;
   localparam int unsigned SHAMT_W = 5;
   localparam int unsigned SUM_W   = SRC_W + 1;
endpackage

// File: rtl/rni_shift_decode.sv
module rni_shift_decode
   import rni_pkg::*;
(
   input  logic [CODE_W-1:0]  code,
   output logic [SHAMT_W-1:0] shamt
);
   // code 0 wraps naturally to 16
   always_comb shamt = SHAMT_W'(DST_W) - {1'b0, code};
endmodule

// File: rtl/rni_lane.sv
module rni_lane
   import rni_pkg::*;
(
   input  logic [SRC_W-1:0]   x,
   input  logic [SHAMT_W-1:0] shamt,
   output logic [DST_W-1:0]   y,
   output logic               clamped
);
   logic [SUM_W-1:0] bias;
   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] shifted;

   always_comb begin
      bias    = SUM_W'(1) << (shamt - SHAMT_W'(1));
      sum     = {1'b0, x} + bias;
      shifted = sum >> shamt;
      clamped = |shifted[SUM_W-1:DST_W];
      y       = clamped ? {DST_W{1'b1}} : shifted[DST_W-1:0];
   end
endmodule

// File: rtl/rni_out_stage.sv
module rni_out_stage #(
   parameter int unsigned W       = 128,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         v_in,
   input  logic [W-1:0] d_in,
   input  logic         f_in,
   output logic         v_out,
   output logic [W-1:0] d_out,
   output logic         f_out
);
   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_out <= 1'b0;
               d_out <= '0;
               f_out <= 1'b0;
            end else begin
               v_out <= v_in;
               if (v_in) begin
                  d_out <= d_in;
                  f_out <= f_in;
               end
            end
         end
      end else begin : g_comb
         logic unused_clk;
         always_comb begin
            unused_clk = clk ^ rst_n;
            v_out      = v_in;
            d_out      = d_in;
            f_out      = f_in;
         end
      end
   endgenerate
endmodule

// File: rtl/round_narrow_interleave.sv
module round_narrow_interleave
   import rni_pkg::*;
#(
   parameter int unsigned LANES   = 4,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [SRC_W*LANES-1:0] src_a,
   input  logic [SRC_W*LANES-1:0] src_b,
   input  logic [CODE_W-1:0]      shift_code,
   output logic                   out_valid,
   output logic [SRC_W*LANES-1:0] dst,
   output logic                   sat_flag
);
   localparam int unsigned VEC_W = SRC_W * LANES;
   localparam int unsigned OUT_N = 2 * LANES;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("round_narrow_interleave: LANES must be at least 1");
      end
      if (VEC_W != DST_W * OUT_N) begin : g_bad_width
         $error("round_narrow_interleave: destination width mismatch");
      end
   endgenerate

   logic [SHAMT_W-1:0] shamt;
   logic [VEC_W-1:0]   packed_res;
   logic [OUT_N-1:0]   clamp_v;

   rni_shift_decode u_dec (
      .code  (shift_code),
      .shamt (shamt)
   );

   generate
      for (genvar e = 0; e < LANES; e++) begin : g_lane
         rni_lane u_even (
            .x       (src_a[e*SRC_W +: SRC_W]),
            .shamt   (shamt),
            .y       (packed_res[(2*e)*DST_W +: DST_W]),
            .clamped (clamp_v[2*e])
         );
         rni_lane u_odd (
            .x       (src_b[e*SRC_W +: SRC_W]),
            .shamt   (shamt),
            .y       (packed_res[(2*e+1)*DST_W +: DST_W]),
            .clamped (clamp_v[2*e+1])
         );
      end
   endgenerate

   rni_out_stage #(
      .W       (VEC_W),
      .REG_OUT (REG_OUT)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .v_in  (in_valid),
      .d_in  (packed_res),
      .f_in  (|clamp_v),
      .v_out (out_valid),
      .d_out (dst),
      .f_out (sat_flag)
   );
endmodule

// File: rtl/rni_checker.sv
module rni_checker
   import rni_pkg::*;
#(
   parameter int unsigned LANES   = 4,
   parameter bit          REG_OUT = 1'b1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic [SRC_W*LANES-1:0] src_a,
   input logic [SRC_W*LANES-1:0] src_b,
   input logic                   out_valid,
   input logic [SRC_W*LANES-1:0] dst,
   input logic                   sat_flag
);
   logic any_max;
   logic zero_in;

   always_comb begin
      any_max = 1'b0;
      for (int k = 0; k < 2*LANES; k++)
         if (dst[k*DST_W +: DST_W] == {DST_W{1'b1}}) any_max = 1'b1;
      zero_in = in_valid && (src_a == '0) && (src_b == '0);
   end

   // R5 / R3: a raised flag means some lane sits at the ceiling
   a_r5_flag_has_max: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && sat_flag) |-> any_max);

   generate
      if (REG_OUT) begin : g_seq
         a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         a_r6_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
         a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(dst) && $stable(sat_flag)));
         a_r2_zero_in_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
            zero_in |=> ((dst == '0) && !sat_flag));
      end else begin : g_comb
         always_comb begin
            if (rst_n && zero_in)
               a_r2_zero_in_zero_out: assert ((dst == '0) && !sat_flag && out_valid);
         end
      end
   endgenerate
endmodule

bind round_narrow_interleave rni_checker #(.LANES(LANES), .REG_OUT(REG_OUT)) u_rni_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .src_a     (src_a),
   .src_b     (src_b),
   .out_valid (out_valid),
   .dst       (dst),
   .sat_flag  (sat_flag)
);

// File: tb/round_narrow_interleave_bench.sv
`timescale 1ns/1ps
module round_narrow_interleave_bench;
   localparam int LANES = 4;
   localparam int VW    = 32 * LANES;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [VW-1:0] src_a = '0;
   logic [VW-1:0] src_b = '0;
   logic [3:0]    shift_code = 4'd0;
   logic          out_valid;
   logic [VW-1:0] dst;
   logic          sat_flag;

   int n_tests = 0;
   int n_fail  = 0;

   logic [VW-1:0] exp_dst  = '0;
   logic          exp_sat  = 1'b0;
   logic          exp_vld  = 1'b0;

   always #2.5 clk = ~clk;

   round_narrow_interleave #(.LANES(LANES), .REG_OUT(1'b1)) u_round_narrow_interleave (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
      .shift_code(shift_code), .out_valid(out_valid), .dst(dst), .sat_flag(sat_flag));

   // behavioural model of one lane
   function automatic void model_lane(input logic [31:0] x, input logic [3:0] c,
                                      output logic [15:0] y, output logic s);
      longint unsigned sh, r;
      sh = 16 - longint'(c);
      r  = (longint'(x) + (64'd1 << (sh - 1))) >> sh;
      s  = (r > 65535);
      y  = s ? 16'hFFFF : r[15:0];
   endfunction

   task automatic check(input string req, input string what, input logic [VW-1:0] act,
                        input logic [VW-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic compare(input string req);
      check(req, "out_valid", VW'(out_valid), VW'(exp_vld));
      check(req, "dst",       dst,            exp_dst);
      check(req, "sat_flag",  VW'(sat_flag),  VW'(exp_sat));
   endtask

   // drive on falling edge, result visible at next falling edge
   task automatic op(input logic v, input logic [VW-1:0] a, input logic [VW-1:0] b,
                     input logic [3:0] c, input string req);
      logic [15:0] y;
      logic        s;
      in_valid = v; src_a = a; src_b = b; shift_code = c;
      @(posedge clk);
      exp_vld = v;
      if (v) begin
         exp_sat = 1'b0;
         for (int e = 0; e < LANES; e++) begin
            model_lane(a[e*32 +: 32], c, y, s);
            exp_dst[(2*e)*16 +: 16] = y;   exp_sat |= s;
            model_lane(b[e*32 +: 32], c, y, s);
            exp_dst[(2*e+1)*16 +: 16] = y; exp_sat |= s;
         end
      end
      @(negedge clk);
      compare(req);
   endtask

   function automatic logic [VW-1:0] fill(input logic [31:0] w);
      logic [VW-1:0] r;
      for (int e = 0; e < LANES; e++) r[e*32 +: 32] = w;
      return r;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      compare("R8");                       // during reset
      rst_n = 1'b1;
      @(negedge clk);
      compare("R8");                       // after release, before any op
      // R1 sweep of every code with a fixed pattern
      for (int c = 0; c < 16; c++)
         op(1'b1, fill(32'h0001_2345 << c), fill(32'h0000_8001), 4'(c), "R1");
      // R2 rounding boundaries at shift 16 and shift 1
      op(1'b1, fill(32'h0000_8000), fill(32'h0000_7FFF), 4'd0, "R2");
      op(1'b1, fill(32'd3), fill(32'd2), 4'd15, "R2");
      // R2 no wrap: all ones with shift 16
      op(1'b1, fill(32'hFFFF_FFFF), fill(32'hFFFF_FFFF), 4'd0, "R2");
      // R3 just below and above the ceiling at shift 16
      op(1'b1, fill(32'hFFFE_FFFF), fill(32'hFFFF_7FFF), 4'd0, "R3");
      op(1'b1, fill(32'hFFFF_8000), fill(32'd0), 4'd0, "R3");
      // R4 distinct per-lane values, R5 single clamped lane
      op(1'b1, {32'h0004_0000, 32'h0003_0000, 32'h0002_0000, 32'h0001_0000},
               {32'h0040_0000, 32'h0030_0000, 32'h0020_0000, 32'h0010_0000}, 4'd0, "R4");
      op(1'b1, '0, {96'd0, 32'h8000_0000}, 4'd8, "R5");
      op(1'b1, '0, '0, 4'd15, "R5");
      // R7 idle cycles keep the last result, R6 valid drops
      op(1'b1, fill(32'h1234_5678), fill(32'hFFFF_FFFF), 4'd4, "R6");
      op(1'b0, fill(32'h0), fill(32'h0), 4'd0, "R7");
      op(1'b0, fill(32'h5555_5555), fill(32'h1), 4'd9, "R7");
      op(1'b1, fill(32'h0000_FFFF), fill(32'h0001_0000), 4'd1, "R6");
      // mixed traffic
      for (int i = 0; i < 60; i++) begin
         logic [VW-1:0] a, b;
         for (int e = 0; e < LANES; e++) begin
            a[e*32 +: 32] = $urandom() >> ($urandom() % 24);
            b[e*32 +: 32] = $urandom();
         end
         op(($urandom() % 4) != 0, a, b, 4'($urandom()), "R6");
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule